// File: doc/BRIEF.md
# Link Test Pattern Sequencer

This block produces self-test traffic for a multi-lane serial link transmitter. A single start pulse launches one run. In that run three traffic sources each take their turn, in an order chosen by a configuration input. One source replays a 24-bit user word a programmable number of times. The second produces a square-wave toggle pattern with a selectable period. The third sends all-zero frames. Each 24-bit pattern leaves the block as two 12-bit frames, one frame per clock, with the low half first.

Every enabled lane carries the same frame. A per-lane enable mask forces the frames of disabled lanes to zero. After the last frame of the third source the block raises a completion flag and goes back to idle. A start that carries a reserved order or period code does not launch a run. It raises an error flag instead.

Top module: `link_pattern_sequencer`

## Requirements
- R1: A start pulse seen while idle, with legal codes, makes `frame_valid` high from the next cycle. It stays high with exactly one new frame per clock until the run ends, so the run lasts 2*loop_cnt + 4 cycles.
- R2: The stored-word source sends `pat_word[11:0]` and then `pat_word[23:12]`, and repeats that pair `loop_cnt` times (1 to 127). A `loop_cnt` of 0 removes this source from the run.
- R3: The toggle source sends one 24-bit word W as two frames, W[11:0] first. Bit i of W is 1 exactly when (i mod P) < P/2. `period_sel` sets P: 001→2, 010→4, 011→6, 100→8, 110→24.
- R4: The constant source sends two all-zero frames.
- R5: `order_sel` sets the source sequence (S = stored word, T = toggle, C = constant): 000 S,T,C; 001 S,C,T; 010 T,S,C; 011 T,C,S; 100 C,S,T; 101 C,T,S.
- R6: Lane k carries `lane_frames[12k+11:12k]`. The lane shows the current frame only while `frame_valid` is high and `lane_mask[k]` is 1; otherwise it is zero. The mask takes effect on the frame in the same cycle, including during a run.
- R7: `done` rises in the cycle after the last frame. It stays high until the next start accepted while idle. It is never high together with `frame_valid`.
- R8: A start while idle with `order_sel` of 110 or 111, or `period_sel` of 000, 101 or 111, sets `cfg_error` from the next cycle, clears `done` and sends no frames. The next start while idle clears `cfg_error`, or keeps it set if its codes are also reserved.
- R9: During a run, start pulses are ignored. This includes a start in the cycle of the last frame. Changes to `pat_word`, `loop_cnt`, `period_sel` and `order_sel` during a run have no effect on it, because they are captured when the start is accepted.
- R10: After reset, `frame_valid`, `done` and `cfg_error` are low and all lanes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launch request, sampled while idle |
| pat_word | input | 24 | User pattern for the stored-word source |
| loop_cnt | input | 7 | Repeat count of the stored word, 0 skips |
| period_sel | input | 3 | Toggle pattern period code |
| order_sel | input | 3 | Source sequence code |
| lane_mask | input | 10 | Per-lane transmit enable |
| frame_valid | output | 1 | High while frames are being sent |
| lane_frames | output | 120 | Ten 12-bit lane frames, lane 0 in the low bits |
| done | output | 1 | Run complete, held until next accepted start |
| cfg_error | output | 1 | Last start carried a reserved code |

## Verification
Two functions can meet in one cycle. One is a start request that arrives while the final frame of a run is on the lanes. The other is a lane mask change that hits a frame mid-run. The bench raises start during the last frame, and during an earlier frame together with new pattern, order, period and count values. It judges that the frame sequence is the one expected from the configuration captured at launch, that `done` still rises on time, and that no second run follows. In the same run it flips the mask mid-stream and checks each following frame against the mask applied in that same cycle.

// File: rtl/link_pattern_sequencer.sv
module link_pattern_sequencer #(
  parameter int LANES   = 10,
  parameter int FRAME_W = 12,
  parameter int LOOP_W  = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2*FRAME_W-1:0]     pat_word,
  input  logic [LOOP_W-1:0]        loop_cnt,
  input  logic [2:0]               period_sel,
  input  logic [2:0]               order_sel,
  input  logic [LANES-1:0]         lane_mask,
  output logic                     frame_valid,
  output logic [LANES*FRAME_W-1:0] lane_frames,
  output logic                     done,
  output logic                     cfg_error
);
  localparam int PAT_W = 2*FRAME_W;
  localparam logic [1:0] SRC_STORE = 2'd0;
  localparam logic [1:0] SRC_MODN  = 2'd1;
  localparam logic [1:0] SRC_CONST = 2'd2;

  function automatic logic [1:0] src_at(input logic [2:0] ord, input logic [1:0] pos);
    logic [7:0] seq;  // slot 0 in the low bits, slot 3 is padding
    case (ord)
      3'd0:    seq = {SRC_CONST, SRC_CONST, SRC_MODN,  SRC_STORE};
      3'd1:    seq = {SRC_CONST, SRC_MODN,  SRC_CONST, SRC_STORE};
      3'd2:    seq = {SRC_CONST, SRC_CONST, SRC_STORE, SRC_MODN};
      3'd3:    seq = {SRC_CONST, SRC_STORE, SRC_CONST, SRC_MODN};
      3'd4:    seq = {SRC_CONST, SRC_MODN,  SRC_STORE, SRC_CONST};
      default: seq = {SRC_CONST, SRC_STORE, SRC_MODN,  SRC_CONST};
    endcase
    return seq[2*pos +: 2];
  endfunction

  function automatic logic [4:0] period_len(input logic [2:0] code);
    case (code)
      3'd1:    return 5'd2;
      3'd2:    return 5'd4;
      3'd3:    return 5'd6;
      3'd4:    return 5'd8;
      3'd6:    return 5'd24;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [PAT_W-1:0] modn_word(input int p);
    logic [PAT_W-1:0] w;
    for (int i = 0; i < PAT_W; i++) w[i] = (i % p) < (p / 2);
    return w;
  endfunction

  function automatic logic [2:0] skip_empty(input logic [2:0] pos, input logic [2:0] ord,
                                            input logic no_loops);
    if (pos < 3'd3 && no_loops && src_at(ord, pos[1:0]) == SRC_STORE) return pos + 3'd1;
    return pos;
  endfunction

  logic                running, half, done_q, err_q;
  logic [1:0]          stage;
  logic [LOOP_W-1:0]   rep, loops_q;
  logic [PAT_W-1:0]    pat_q, modn_cur;
  logic [2:0]          per_q, ord_q;
  logic [FRAME_W-1:0]  frame;

  wire       start_bad  = (order_sel[2:1] == 2'b11) || (period_len(period_sel) == 5'd0);
  wire [2:0] first_pos  = skip_empty(3'd0, order_sel, loop_cnt == '0);
  wire [1:0] cur_src    = src_at(ord_q, stage);
  wire       store_last = (rep == loops_q - 1'b1);
  wire       stage_end  = half && (cur_src != SRC_STORE || store_last);
  wire [2:0] next_pos   = skip_empty({1'b0, stage} + 3'd1, ord_q, loops_q == '0);

  always_comb
    case (per_q)
      3'd1:    modn_cur = modn_word(2);
      3'd2:    modn_cur = modn_word(4);
      3'd3:    modn_cur = modn_word(6);
      3'd4:    modn_cur = modn_word(8);
      default: modn_cur = modn_word(24);
    endcase

  always_comb
    case (cur_src)
      SRC_STORE: frame = half ? pat_q[PAT_W-1:FRAME_W] : pat_q[FRAME_W-1:0];
      SRC_MODN:  frame = half ? modn_cur[PAT_W-1:FRAME_W] : modn_cur[FRAME_W-1:0];
      default:   frame = '0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      running <= 1'b0;
      half    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      stage   <= '0;
      rep     <= '0;
      loops_q <= '0;
      pat_q   <= '0;
      per_q   <= 3'd1;
      ord_q   <= '0;
    end else if (!running) begin
      if (start) begin
        done_q <= 1'b0;
        err_q  <= start_bad;
        if (!start_bad) begin
          running <= 1'b1;
          stage   <= first_pos[1:0];
          rep     <= '0;
          half    <= 1'b0;
          pat_q   <= pat_word;
          loops_q <= loop_cnt;
          per_q   <= period_sel;
          ord_q   <= order_sel;
        end
      end
    end else if (!half) begin
      half <= 1'b1;
    end else begin
      half <= 1'b0;
      if (!stage_end) rep <= rep + 1'b1;
      else begin
        rep <= '0;
        if (next_pos == 3'd3) begin
          running <= 1'b0;
          done_q  <= 1'b1;
        end else stage <= next_pos[1:0];
      end
    end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_frames[k*FRAME_W +: FRAME_W] = (running && lane_mask[k]) ? frame : '0;
  end

  assign frame_valid = running;
  assign done        = done_q;
  assign cfg_error   = err_q;
endmodule

module link_pattern_sequencer_chk #(
  parameter int LANES   = 10,
  parameter int FRAME_W = 12
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic [2:0]               period_sel,
  input logic [2:0]               order_sel,
  input logic [LANES-1:0]         lane_mask,
  input logic                     frame_valid,
  input logic [LANES*FRAME_W-1:0] lane_frames,
  input logic                     done,
  input logic                     cfg_error
);
  wire per_ok = period_sel inside {3'd1, 3'd2, 3'd3, 3'd4, 3'd6};
  wire ord_ok = order_sel[2:1] != 2'b11;

  a_r1_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_valid && start && per_ok && ord_ok) |=> frame_valid);

  a_r6_idle_lanes_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> lane_frames == '0);

  for (genvar k = 0; k < LANES; k++) begin : g_mask
    a_r6_masked_lane_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_mask[k] |-> lane_frames[k*FRAME_W +: FRAME_W] == '0);
  end

  a_r7_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_valid) |-> done);

  a_r7_done_excludes_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && frame_valid));

  a_r8_reserved_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_valid && start && !(per_ok && ord_ok)) |=> (cfg_error && !frame_valid && !done));

  a_r8_error_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_error |-> !frame_valid);
endmodule

bind link_pattern_sequencer link_pattern_sequencer_chk #(.LANES(LANES), .FRAME_W(FRAME_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .period_sel(period_sel), .order_sel(order_sel),
  .lane_mask(lane_mask), .frame_valid(frame_valid), .lane_frames(lane_frames),
  .done(done), .cfg_error(cfg_error)
);

// File: tb/link_pattern_sequencer_tb_top.sv
module link_pattern_sequencer_tb_top;
  localparam int LANES = 10;
  localparam int FW    = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [23:0]       pat_word = 24'h02CCFD;
  logic [6:0]        loop_cnt = 7'd15;
  logic [2:0]        period_sel = 3'd1;
  logic [2:0]        order_sel = 3'd0;
  logic [LANES-1:0]  lane_mask = '1;
  logic              frame_valid, done, cfg_error;
  logic [LANES*FW-1:0] lane_frames;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [FW-1:0] exp_f [0:299];
  int exp_n;

  always #2 clk = ~clk;

  link_pattern_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pat_word(pat_word), .loop_cnt(loop_cnt),
    .period_sel(period_sel), .order_sel(order_sel), .lane_mask(lane_mask),
    .frame_valid(frame_valid), .lane_frames(lane_frames), .done(done), .cfg_error(cfg_error)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic build_exp(input logic [23:0] pw, input int lp, input logic [2:0] ps,
                           input logic [2:0] os);
    int seq [3];
    int p;
    logic [23:0] mw;
    case (os)
      3'd0: seq = '{0, 1, 2};
      3'd1: seq = '{0, 2, 1};
      3'd2: seq = '{1, 0, 2};
      3'd3: seq = '{1, 2, 0};
      3'd4: seq = '{2, 0, 1};
      default: seq = '{2, 1, 0};
    endcase
    case (ps)
      3'd1: p = 2;
      3'd2: p = 4;
      3'd3: p = 6;
      3'd4: p = 8;
      default: p = 24;
    endcase
    for (int i = 0; i < 24; i++) mw[i] = (i % p) < (p / 2);
    exp_n = 0;
    for (int s = 0; s < 3; s++) begin
      if (seq[s] == 0) begin
        for (int r = 0; r < lp; r++) begin
          exp_f[exp_n] = pw[11:0];  exp_n++;
          exp_f[exp_n] = pw[23:12]; exp_n++;
        end
      end else if (seq[s] == 1) begin
        exp_f[exp_n] = mw[11:0];  exp_n++;
        exp_f[exp_n] = mw[23:12]; exp_n++;
      end else begin
        exp_f[exp_n] = '0; exp_n++;
        exp_f[exp_n] = '0; exp_n++;
      end
    end
  endtask

  // inj_at >= 0: at that frame raise start and disturb the configuration and mask
  task automatic t_run(input logic [23:0] pw, input int lp, input logic [2:0] ps,
                       input logic [2:0] os, input logic [LANES-1:0] msk, input int inj_at,
                       input logic [LANES-1:0] inj_msk, input string tag);
    int n = 0;
    int bad = 0;
    longint got_v = 0, exp_v = 0;
    build_exp(pw, lp, ps, os);
    pat_word = pw; loop_cnt = lp[6:0]; period_sel = ps; order_sel = os; lane_mask = msk;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(frame_valid === 1'b1, "R1 valid after start", frame_valid, 1);
    chk(done === 1'b0 && cfg_error === 1'b0, "R7 flags cleared at start", {done, cfg_error}, 0);
    while (frame_valid && n < 300) begin
      for (int k = 0; k < LANES; k++) begin
        logic [FW-1:0] want = lane_mask[k] ? exp_f[n] : '0;
        if (lane_frames[k*FW +: FW] !== want && bad == 0) begin
          bad = 1; got_v = lane_frames[k*FW +: FW]; exp_v = want;
        end
      end
      if (n == inj_at) begin
        start = 1'b1; pat_word = ~pat_word; order_sel = 3'd5 - order_sel;
        period_sel = 3'd6; loop_cnt = 7'd1; lane_mask = inj_msk;
      end
      n++;
      @(negedge clk);
      start = 1'b0;
    end
    chk(n == exp_n, "R1 frame count", n, exp_n);
    chk(bad == 0, tag, got_v, exp_v);
    chk(done === 1'b1, "R7 done after last frame", done, 1);
    @(negedge clk);
    chk(frame_valid === 1'b0 && done === 1'b1, "R9 no relaunch from start during run",
        {frame_valid, done}, 1);
  endtask

  task automatic t_bad(input logic [2:0] ps, input logic [2:0] os, input string tag);
    period_sel = ps; order_sel = os;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 6; c++) begin
      chk(frame_valid === 1'b0 && lane_frames == '0, tag, {frame_valid, lane_frames}, 0);
      @(negedge clk);
    end
    chk(cfg_error === 1'b1 && done === 1'b0, "R8 error flag set, done clear",
        {cfg_error, done}, 2);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(frame_valid === 1'b0 && done === 1'b0 && cfg_error === 1'b0 && lane_frames === '0,
        "R10 reset outputs", {frame_valid, done, cfg_error, lane_frames}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frame_valid === 1'b0, "R10 idle after reset", frame_valid, 0);
  endtask

  initial begin
    t_reset();
    t_run(24'h02CCFD, 2,   3'd1, 3'd0, '1, -1, '1, "R2 R3 R4 R5 order 000 period 2");
    t_run(24'hA5C3F0, 1,   3'd6, 3'd3, '1, -1, '1, "R3 R5 order 011 period 24");
    t_run(24'h123456, 3,   3'd3, 3'd5, '1, -1, '1, "R3 R5 order 101 period 6");
    t_run(24'hFFFFFF, 0,   3'd4, 3'd1, '1, -1, '1, "R2 zero loops skip, period 8");
    t_run(24'h0F0F0F, 127, 3'd2, 3'd2, '1, -1, '1, "R2 R5 max loops order 010 period 4");
    t_run(24'h9ABCDE, 2,   3'd1, 3'd4, 10'b1010101010, 3, 10'b0101010101, "R6 mask live");
    t_bad(3'd1, 3'd6, "R8 order 110 silent");
    t_bad(3'd0, 3'd0, "R8 period 000 silent");
    t_bad(3'd5, 3'd1, "R8 period 101 silent");
    t_bad(3'd7, 3'd7, "R8 order 111 period 111 silent");
    t_run(24'h3C3C3C, 2,   3'd3, 3'd0, '1, 1,  '1, "R9 config frozen during run");
    t_run(24'h5A5A5A, 1,   3'd2, 3'd4, '1, 5,  '1, "R9 start on last frame ignored");
    t_run(24'h00CAFE, 1,   3'd6, 3'd1, 10'd0, -1, 10'd0, "R6 all lanes masked");
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule